// File: doc/BRIEF.md
# Level-Sensitive Interrupt Entry Sequencer

This block is the interrupt acceptance and entry logic of a small 8-bit processor core. An external device drives a level request line. The core looks at that line only at instruction boundaries, which a stub strobe marks in place of the real decode logic. If the line is high and the interrupt-mask flag is clear at that moment, the block runs a fixed seven-cycle entry. The entry saves the return address and a status image on the stack, raises the mask, and loads the program counter from a fixed vector. If the request is not taken, the boundary simply starts the next opcode fetch.

The core never captures or clears the request. Each boundary reads the line afresh. A device that keeps the line high because its handler has not acknowledged it gets a second entry as soon as the mask drops. Flag, program counter and stack pointer updates made by the completing instruction (for example a return-from-interrupt) count at the same boundary.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the program counter is PC_RESET (0x8000), the stack pointer is SP_RESET (0xFD), the status is 0x24 (mask bit 2 set, bit 5 set), and `entry_busy_o`, `fetch_o`, `mem_we` and `mem_re` are all low.
- R2: The request is sampled only in a cycle where `instr_done` is high. A request held while `instr_done` is low never starts an entry.
- R3: A boundary with the request high starts no entry when the effective mask bit (status bit 2) is 1. No memory access occurs and the status is unchanged.
- R4: The request is not stored. A request that rises and falls between two boundaries leaves the next boundary (with the request low) as a plain fetch.
- R5: The entry writes three bytes to page 0x01, at {0x01, SP}, then SP-1, then SP-2. The bytes are the PC high byte, then the PC low byte, then the status image. SP ends at SP-3.
- R6: In the pushed status image, bit 4 is forced to 0, bit 5 is forced to 1, and every other bit is a copy of the status.
- R7: After the entry, status bit 2 is 1 and the other status bits are unchanged. The PC equals {byte at 0xFFFF, byte at 0xFFFE}, read in that order: low byte first.
- R8: `entry_busy_o` is high for exactly 7 cycles, starting the cycle after the accepting boundary. `fetch_o` pulses for one cycle right after the entry ends.
- R9: Flag, PC and SP writes that arrive with `instr_done` are applied before the decision. A request that is still held when such a write clears the mask is taken at that same boundary, and the written PC is pushed.
- R10: A boundary that does not take an interrupt gives a one-cycle `fetch_o` pulse in the next cycle and leaves the PC unchanged.
- R11: During an entry, `instr_done`, `flag_we`, `pc_we` and `sp_we` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Level interrupt request from external logic |
| instr_done | input | 1 | Instruction boundary strobe from the stub decoder |
| flag_we | input | 1 | Status write by the completing instruction |
| flag_wdata | input | 8 | Status value to write |
| pc_we | input | 1 | PC write by the completing instruction |
| pc_wdata | input | 16 | PC value to write |
| sp_we | input | 1 | Stack pointer write by the completing instruction |
| sp_wdata | input | 8 | Stack pointer value to write |
| mem_rdata | input | 8 | Read data, valid in the same cycle as `mem_re` |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| pc_o | output | 16 | Program counter |
| sp_o | output | 8 | Stack pointer |
| status_o | output | 8 | Status flags |
| fetch_o | output | 1 | Opcode fetch start pulse |
| entry_busy_o | output | 1 | Entry sequence in progress |

## Verification
A wrong sequencer state shows up within one to eight cycles. It appears as a busy window that is not seven cycles long, as stray stack writes or a wrong write order, or as a fetch pulse where an entry should have begun. A wrong mask decision shows up the cycle after the boundary: either busy goes high or fetch pulses. Corrupt push data or a bad vector assembly is visible on the write bus and on the PC once the window closes. The held-request case is the sharpest test: the return boundary must start a second entry at once and push the restored PC.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 16;

    // status bit positions that the entry logic depends on
    localparam int unsigned MASK_BIT  = 2;
    localparam int unsigned BRK_BIT   = 4;
    localparam int unsigned ONE_BIT   = 5;

    localparam int unsigned ENTRY_CYCLES = 7;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_IDLE1,
        ST_IDLE2,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_PUSH_P,
        ST_VEC_LO,
        ST_VEC_HI
    } seq_state_e;

    typedef struct packed {
        seq_state_e          state;
        logic [ADDR_W-1:0]   pc;
        logic [DATA_W-1:0]   sp;
        logic [DATA_W-1:0]   status;
        logic [DATA_W-1:0]   vec_lo;
        logic                fetch;
    } seq_regs_t;
endpackage

// File: rtl/irq_accept_gate.sv
module irq_accept_gate
    import irq_seq_pkg::*;
(
    input  logic              irq_req,
    input  logic              instr_done,
    input  logic              busy,
    input  logic              flag_we,
    input  logic [DATA_W-1:0] flag_wdata,
    input  logic [DATA_W-1:0] status_q,
    output logic              take,
    output logic              plain_boundary
);
    logic boundary;
    logic mask_eff;

    always_comb begin
        boundary       = instr_done && !busy;
        mask_eff       = flag_we ? flag_wdata[MASK_BIT] : status_q[MASK_BIT];
        take           = boundary && irq_req && !mask_eff;
        plain_boundary = boundary && !take;
    end
endmodule

// File: rtl/irq_push_mux.sv
module irq_push_mux
    import irq_seq_pkg::*;
(
    input  seq_state_e        state,
    input  logic [ADDR_W-1:0] pc,
    input  logic [DATA_W-1:0] status,
    output logic              push_en,
    output logic [DATA_W-1:0] push_data
);
    logic [DATA_W-1:0] image;

    for (genvar b = 0; b < DATA_W; b++) begin : g_img
        if (b == BRK_BIT) begin : g_brk
            assign image[b] = 1'b0;
        end else if (b == ONE_BIT) begin : g_one
            assign image[b] = 1'b1;
        end else begin : g_copy
            assign image[b] = status[b];
        end
    end

    always_comb begin
        push_en   = 1'b0;
        push_data = '0;
        unique case (state)
            ST_PUSH_HI: begin push_en = 1'b1; push_data = pc[ADDR_W-1:DATA_W]; end
            ST_PUSH_LO: begin push_en = 1'b1; push_data = pc[DATA_W-1:0];      end
            ST_PUSH_P:  begin push_en = 1'b1; push_data = image;               end
            default:    begin push_en = 1'b0; push_data = '0;                  end
        endcase
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter logic [15:0] PC_RESET   = 16'h8000,
    parameter logic [7:0]  SP_RESET   = 8'hFD,
    parameter logic [7:0]  STACK_PAGE = 8'h01,
    parameter logic [15:0] VEC_ADDR   = 16'hFFFE,
    parameter logic [7:0]  STAT_RESET = 8'h24
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        irq_req,
    input  logic        instr_done,
    input  logic        flag_we,
    input  logic [7:0]  flag_wdata,
    input  logic        pc_we,
    input  logic [15:0] pc_wdata,
    input  logic        sp_we,
    input  logic [7:0]  sp_wdata,
    input  logic [7:0]  mem_rdata,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        mem_we,
    output logic        mem_re,
    output logic [15:0] pc_o,
    output logic [7:0]  sp_o,
    output logic [7:0]  status_o,
    output logic        fetch_o,
    output logic        entry_busy_o
);
    localparam logic [15:0] VEC_ADDR_HI = VEC_ADDR + 16'd1;

    seq_regs_t r_q, r_d;

    logic              busy;
    logic              take;
    logic              plain_boundary;
    logic              push_en;
    logic [DATA_W-1:0] push_data;

    assign busy = (r_q.state != ST_RUN);

    irq_accept_gate u_gate (
        .irq_req        (irq_req),
        .instr_done     (instr_done),
        .busy           (busy),
        .flag_we        (flag_we),
        .flag_wdata     (flag_wdata),
        .status_q       (r_q.status),
        .take           (take),
        .plain_boundary (plain_boundary)
    );

    irq_push_mux u_push (
        .state     (r_q.state),
        .pc        (r_q.pc),
        .status    (r_q.status),
        .push_en   (push_en),
        .push_data (push_data)
    );

    always_comb begin
        r_d       = r_q;
        r_d.fetch = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;

        if (push_en) begin
            mem_we    = 1'b1;
            mem_addr  = {STACK_PAGE, r_q.sp};
            mem_wdata = push_data;
            r_d.sp    = r_q.sp - 8'd1;
        end

        unique case (r_q.state)
            ST_RUN: begin
                if (flag_we) r_d.status = flag_wdata;
                if (pc_we)   r_d.pc     = pc_wdata;
                if (sp_we)   r_d.sp     = sp_wdata;
                if (take)
                    r_d.state = ST_IDLE1;
                else if (plain_boundary)
                    r_d.fetch = 1'b1;
            end
            ST_IDLE1:   r_d.state = ST_IDLE2;
            ST_IDLE2:   r_d.state = ST_PUSH_HI;
            ST_PUSH_HI: r_d.state = ST_PUSH_LO;
            ST_PUSH_LO: r_d.state = ST_PUSH_P;
            ST_PUSH_P: begin
                r_d.status[MASK_BIT] = 1'b1;
                r_d.state            = ST_VEC_LO;
            end
            ST_VEC_LO: begin
                mem_re     = 1'b1;
                mem_addr   = VEC_ADDR;
                r_d.vec_lo = mem_rdata;
                r_d.state  = ST_VEC_HI;
            end
            ST_VEC_HI: begin
                mem_re    = 1'b1;
                mem_addr  = VEC_ADDR_HI;
                r_d.pc    = {mem_rdata, r_q.vec_lo};
                r_d.fetch = 1'b1;
                r_d.state = ST_RUN;
            end
            default: r_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state  <= ST_RUN;
            r_q.pc     <= PC_RESET;
            r_q.sp     <= SP_RESET;
            r_q.status <= STAT_RESET;
            r_q.vec_lo <= '0;
            r_q.fetch  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pc_o         = r_q.pc;
    assign sp_o         = r_q.sp;
    assign status_o     = r_q.status;
    assign fetch_o      = r_q.fetch;
    assign entry_busy_o = busy;
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        irq_req,
    input logic        instr_done,
    input logic [15:0] mem_addr,
    input logic [7:0]  mem_wdata,
    input logic        mem_we,
    input logic        mem_re,
    input logic [7:0]  sp_o,
    input logic [7:0]  status_o,
    input logic        fetch_o,
    input logic        entry_busy_o
);
    logic [3:0] busy_len;

    always_ff @(posedge clk) begin
        if (!rst_n)            busy_len <= '0;
        else if (entry_busy_o) busy_len <= busy_len + 4'd1;
        else                   busy_len <= '0;
    end

    // R2: an entry only starts from a boundary with the request high
    p_start_at_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(entry_busy_o) |-> ($past(instr_done) && $past(irq_req)));

    // R5: every write lands on the stack page and steps SP down
    p_write_stack_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[15:8] == 8'h01));

    p_sp_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp_o == $past(sp_o) - 8'd1));

    // R6: third consecutive write is the status image
    p_status_image_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we) && $past(mem_we, 2)) |-> (!mem_wdata[4] && mem_wdata[5]));

    // R7: mask set once entry completes
    p_mask_after_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(entry_busy_o) |-> status_o[2]);

    // R8: fixed window length and fetch pulse afterwards
    p_window_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(entry_busy_o) |-> (busy_len == 4'd7));

    p_fetch_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(entry_busy_o) |-> fetch_o);

    // R10: fetch never overlaps an entry; memory only used inside one
    p_fetch_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_o |-> !entry_busy_o);

    p_mem_in_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> entry_busy_o);
endmodule

bind irq_entry_seq irq_entry_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_req      (irq_req),
    .instr_done   (instr_done),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_we       (mem_we),
    .mem_re       (mem_re),
    .sp_o         (sp_o),
    .status_o     (status_o),
    .fetch_o      (fetch_o),
    .entry_busy_o (entry_busy_o)
);

// File: tb/irq_entry_seq_bench.sv
`timescale 1ns/1ps
module irq_entry_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        irq_req, instr_done, flag_we, pc_we, sp_we;
    logic [7:0]  flag_wdata, sp_wdata, mem_rdata;
    logic [15:0] pc_wdata;
    logic [15:0] mem_addr, pc_o;
    logic [7:0]  mem_wdata, sp_o, status_o;
    logic        mem_we, mem_re, fetch_o, entry_busy_o;

    localparam logic [7:0]  VLO = 8'h34;
    localparam logic [7:0]  VHI = 8'hE1;

    int checks = 0;
    int fails  = 0;
    int wn     = 0;
    logic [15:0] wa [0:31];
    logic [7:0]  wd [0:31];

    always #2.5 clk = ~clk;

    assign mem_rdata = (mem_addr == 16'hFFFE) ? VLO :
                       (mem_addr == 16'hFFFF) ? VHI : 8'h00;

    irq_entry_seq u_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .instr_done(instr_done),
        .flag_we(flag_we), .flag_wdata(flag_wdata), .pc_we(pc_we), .pc_wdata(pc_wdata),
        .sp_we(sp_we), .sp_wdata(sp_wdata), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .pc_o(pc_o), .sp_o(sp_o), .status_o(status_o), .fetch_o(fetch_o),
        .entry_busy_o(entry_busy_o)
    );

    always @(negedge clk) begin
        if (mem_we && wn < 32) begin
            wa[wn] = mem_addr;
            wd[wn] = mem_wdata;
            wn++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step;
        @(negedge clk); #1;
    endtask

    task automatic boundary(input logic irq, input logic fwe, input logic [7:0] fd,
                            input logic pwe, input logic [15:0] pd,
                            input logic swe, input logic [7:0] sd);
        step();
        irq_req = irq; instr_done = 1'b1;
        flag_we = fwe; flag_wdata = fd; pc_we = pwe; pc_wdata = pd; sp_we = swe; sp_wdata = sd;
        step();
        instr_done = 1'b0; flag_we = 1'b0; pc_we = 1'b0; sp_we = 1'b0;
    endtask

    // called one cycle after an accepting boundary
    task automatic run_entry(input logic [15:0] ret, input logic [7:0] img,
                             input logic [7:0] sp0, input logic [7:0] st_after, input bit poke);
        int base;
        int busy_cnt;
        base = wn;
        busy_cnt = 0;
        for (int k = 1; k <= 7; k++) begin
            if (entry_busy_o) busy_cnt++;
            if (k == 6) chk(mem_re && mem_addr == 16'hFFFE, "R7 vec lo read", mem_addr, 16'hFFFE);
            if (k == 7) chk(mem_re && mem_addr == 16'hFFFF, "R7 vec hi read", mem_addr, 16'hFFFF);
            if (poke && k == 2) begin
                instr_done = 1'b1; flag_we = 1'b1; flag_wdata = 8'h00;
                pc_we = 1'b1; pc_wdata = 16'h0BAD; sp_we = 1'b1; sp_wdata = 8'h10;
            end else begin
                instr_done = 1'b0; flag_we = 1'b0; pc_we = 1'b0; sp_we = 1'b0;
            end
            step();
        end
        instr_done = 1'b0; flag_we = 1'b0; pc_we = 1'b0; sp_we = 1'b0;
        chk(busy_cnt == 7, "R8 busy cycles", busy_cnt, 7);
        chk(!entry_busy_o && fetch_o, "R8 fetch after entry", {entry_busy_o, fetch_o}, 2'b01);
        chk(wn - base == 3, "R5 write count", wn - base, 3);
        chk(wa[base] == {8'h01, sp0} && wd[base] == ret[15:8], "R5 PC high push",
            {wa[base], wd[base]}, {8'h01, sp0, ret[15:8]});
        chk(wa[base+1] == {8'h01, 8'(sp0 - 8'd1)} && wd[base+1] == ret[7:0], "R5 PC low push",
            {wa[base+1], wd[base+1]}, {8'h01, 8'(sp0 - 8'd1), ret[7:0]});
        chk(wa[base+2] == {8'h01, 8'(sp0 - 8'd2)}, "R5 status push addr", wa[base+2], {8'h01, 8'(sp0 - 8'd2)});
        chk(wd[base+2] == img, "R6 pushed status image", wd[base+2], img);
        chk(sp_o == 8'(sp0 - 8'd3), "R5 final SP", sp_o, 8'(sp0 - 8'd3));
        chk(pc_o == {VHI, VLO}, "R7 vector PC", pc_o, {VHI, VLO});
        chk(status_o == st_after, "R7 status after entry", status_o, st_after);
        if (poke) chk(status_o == st_after && pc_o == {VHI, VLO}, "R11 writes during entry ignored",
                      {pc_o, status_o}, {VHI, VLO, st_after});
        step();
        chk(!fetch_o, "R8 fetch single cycle", fetch_o, 0);
    endtask

    task automatic t_reset;
        step();
        chk(pc_o == 16'h8000, "R1 reset PC", pc_o, 16'h8000);
        chk(sp_o == 8'hFD, "R1 reset SP", sp_o, 8'hFD);
        chk(status_o == 8'h24, "R1 reset status", status_o, 8'h24);
        chk(!entry_busy_o && !fetch_o && !mem_we && !mem_re, "R1 reset idle",
            {entry_busy_o, fetch_o, mem_we, mem_re}, 0);
    endtask

    task automatic t_plain;
        boundary(1'b0, 1'b0, 8'h00, 1'b0, 16'h0, 1'b0, 8'h00);
        chk(fetch_o && !entry_busy_o, "R10 plain boundary fetch", {fetch_o, entry_busy_o}, 2'b10);
        chk(pc_o == 16'h8000, "R10 PC unchanged", pc_o, 16'h8000);
        step();
        chk(!fetch_o, "R10 fetch one cycle", fetch_o, 0);
    endtask

    task automatic t_masked;
        int w0;
        w0 = wn;
        boundary(1'b1, 1'b0, 8'h00, 1'b0, 16'h0, 1'b0, 8'h00);
        chk(fetch_o && !entry_busy_o, "R3 masked boundary fetches", {fetch_o, entry_busy_o}, 2'b10);
        step(); step();
        chk(wn == w0 && status_o == 8'h24, "R3 masked no push", {wn[7:0], status_o}, {w0[7:0], 8'h24});
        irq_req = 1'b0;
    endtask

    task automatic t_mid_instr;
        int busy_seen;
        busy_seen = 0;
        boundary(1'b0, 1'b1, 8'h20, 1'b0, 16'h0, 1'b0, 8'h00);
        irq_req = 1'b1;
        for (int k = 0; k < 6; k++) begin
            step();
            if (entry_busy_o) busy_seen++;
        end
        chk(busy_seen == 0, "R2 no entry between boundaries", busy_seen, 0);
        irq_req = 1'b0;
    endtask

    task automatic t_pulse;
        step();
        irq_req = 1'b1; step(); step(); step();
        irq_req = 1'b0; step();
        boundary(1'b0, 1'b0, 8'h00, 1'b0, 16'h0, 1'b0, 8'h00);
        chk(fetch_o && !entry_busy_o, "R4 released request not kept", {fetch_o, entry_busy_o}, 2'b10);
    endtask

    task automatic t_entry_and_retake;
        // boundary writes PC and status (B set, mask clear) together with held request
        boundary(1'b1, 1'b1, 8'hD3, 1'b1, 16'h4567, 1'b0, 8'h00);
        chk(entry_busy_o, "R9 writes applied before decision", entry_busy_o, 1);
        run_entry(16'h4567, 8'hE3, 8'hFD, 8'hD7, 1'b1);
        // handler boundary: request still held, mask set
        boundary(1'b1, 1'b0, 8'h00, 1'b0, 16'h0, 1'b0, 8'h00);
        chk(fetch_o && !entry_busy_o, "R3 held request masked in handler", {fetch_o, entry_busy_o}, 2'b10);
        // return: restore status image, PC and SP; request still held
        boundary(1'b1, 1'b1, 8'hE3, 1'b1, 16'h4567, 1'b1, 8'hFD);
        chk(entry_busy_o && !fetch_o, "R9 retaken at return boundary", {entry_busy_o, fetch_o}, 2'b10);
        run_entry(16'h4567, 8'hE3, 8'hFD, 8'hE7, 1'b0);
        irq_req = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; irq_req = 1'b0; instr_done = 1'b0;
        flag_we = 1'b0; flag_wdata = '0; pc_we = 1'b0; pc_wdata = '0; sp_we = 1'b0; sp_wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_plain();
        t_masked();
        t_mid_instr();
        t_pulse();
        t_entry_and_retake();
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule